// File: doc/BRIEF.md
# Two-Stage Programmable Digital Crosspoint

This block is a non-blocking N-by-N digital crosspoint. Each output has its own multiplexer and can take its data from any input, so one input can feed any number of outputs at the same time. Each output's source choice is stored in two stages. A staged register receives new values from the programming interfaces. A live register drives the multiplexer. A whole new routing can therefore be built up quietly and then switched in with a single commit.

There are two ways to fill the staged registers. A per-port interface captures a source index and a destination index on the falling edge of a load strobe, but only when the mode select is low. A wide interface writes every output's source in one cycle from a flat vector and carries its own commit pulse. An active-low configure input also commits. The block reset steers every output to input 0 and leaves the staged choices alone, so one configure after reset brings back the user's routing. A ready flag reports when a load or a commit has finished. All strobes are sampled and edge-detected on the single system clock.

Top module: `xbar_two_stage`

## Requirements
- R1: Output k carries `din[k]`'s chosen source exactly: `dout[k] == din[live_k]`, combinationally. Two or more outputs may select the same input.
- R2: With `port_mode_n` low, a falling edge of `ld_stb`, seen as high on one clock and low on the next, writes `src_idx` into the staged choice of output `dst_idx` only. The outputs do not change until a commit.
- R3: With `port_mode_n` high, a falling edge of `ld_stb` leaves every staged choice unchanged.
- R4: On every clock edge at which `cfg_n` is low or `seq_commit` is high, all staged choices are copied to the live registers. The outputs follow from that edge.
- R5: A live choice changes only at a commit edge or at a reset edge. An output whose choice is the same before and after a commit passes its data without interruption.
- R6: At a clock edge with `rst_n` low, every live choice becomes 0, so every output carries input 0, and `ready` becomes 0.
- R7: Reset, and any strobe that arrives while reset is low, leave the staged choices unchanged. The first commit after reset restores the routing that was programmed before it.
- R8: `ready` goes to 0 on the edge after `cfg_n` is seen low, or after a rising edge of `ld_stb`. Clearing takes precedence over setting.
- R9: `ready` goes to 1 after a capture as described in R2, after `cfg_n` returns high, or after a `seq_commit` pulse.
- R10: `seq_load` high writes the staged choice of every output k from `seq_sel[k*4 +: 4]` (with 16 ports) in one edge. Nothing becomes live before a commit.
- R11: Holding `ld_stb` low captures only once. A change on `src_idx` after the falling edge has no effect.
- R12: If `seq_load` and a per-port capture fall on the same edge, the wide vector wins for every output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset of the live routing and the flags |
| din | input | N_PORTS*DATA_W | Input port data, port j at bits [j*DATA_W +: DATA_W] |
| dout | output | N_PORTS*DATA_W | Output port data, port k at bits [k*DATA_W +: DATA_W] |
| port_mode_n | input | 1 | Low selects per-port programming; high ignores the per-port address pair |
| ld_stb | input | 1 | Load strobe; its falling edge captures the address pair |
| src_idx | input | SEL_W | Input index to be staged |
| dst_idx | input | SEL_W | Output whose staged choice is written |
| cfg_n | input | 1 | Active-low configure: copy staged choices to live |
| seq_sel | input | N_PORTS*SEL_W | Staged choices for all outputs, output k at bits [k*SEL_W +: SEL_W] |
| seq_load | input | 1 | Write all staged choices from seq_sel |
| seq_commit | input | 1 | One-clock commit pulse from the wide interface |
| ready | output | 1 | Load or commit completed |

## Verification
The bench checks that a capture changes nothing at the outputs until a commit. It also checks that a reset steers everything to input 0 but keeps the staged routing: a design that cleared the staged registers would come back from the post-reset configure with everything still on input 0. The bench holds the load strobe low while it changes the source, and it pulses the strobe with the mode select high. Either mistake shows up as a changed route after the next commit, one from a level-sensitive capture and the other from an ignored mode. The bench collides a wide write with a per-port capture to confirm the precedence. It checks data continuity on an unchanged output across a commit, and it follows `ready` through each event that sets or clears it.

// File: rtl/xbs_pkg.sv
// Shared defaults for the two-stage crosspoint.
// Assumes: port count is a power of two or the select width rounds up.
package xbs_pkg;
    localparam int unsigned XBS_PORTS_DEF = 16;
    localparam int unsigned XBS_DATA_DEF  = 1;

    // Width of an index that can name any of n ports.
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction
endpackage

// File: rtl/xbs_ctrl.sv
// Strobe sampling and ready flag for the crosspoint.
// Samples ld_stb and cfg_n once per clock. It produces a one-cycle per-port
// write enable on a falling load edge in port mode and a commit request.
// It also runs the ready flag.
// Assumes: strobes are already synchronous to clk.
module xbs_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic port_mode_n,
    input  logic ld_stb,
    input  logic cfg_n,
    input  logic seq_commit,
    output logic port_wr,
    output logic commit,
    output logic ready
);
    logic ld_q;
    logic cfg_q;
    logic ld_rise;
    logic ld_fall;
    logic cfg_rise;
    logic rdy_clr;
    logic rdy_set;

    assign ld_rise  = ld_stb & ~ld_q;
    assign ld_fall  = ~ld_stb & ld_q;
    assign cfg_rise = cfg_n & ~cfg_q;
    assign port_wr  = rst_n & ld_fall & ~port_mode_n;
    assign commit   = rst_n & (~cfg_n | seq_commit);
    assign rdy_clr  = ~cfg_n | ld_rise;
    assign rdy_set  = port_wr | cfg_rise | seq_commit;

    // Keep last-cycle samples of the strobes for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ld_q  <= 1'b0;
            cfg_q <= 1'b1;
        end else begin
            ld_q  <= ld_stb;
            cfg_q <= cfg_n;
        end
    end

    // Ready flag: reset and clear events dominate set events.
    always_ff @(posedge clk) begin
        if (!rst_n)       ready <= 1'b0;
        else if (rdy_clr) ready <= 1'b0;
        else if (rdy_set) ready <= 1'b1;
    end

    // R8
    ready_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_n || (ld_stb && !ld_q)) |=> !ready);
    // R9
    ready_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_n && !(ld_stb && !ld_q) && (port_wr || seq_commit)) |=> ready);
    // R6
    ready_rst_chk: assert property (@(posedge clk) !rst_n |=> !ready);
    // R11
    single_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        port_wr |=> !port_wr);
endmodule

// File: rtl/xbs_sel_bank.sv
// Staged and live source choices for every output.
// Staged choices are written by the per-port or the wide interface (the wide
// one wins) and are never cleared by reset. Live choices copy all staged
// choices on a commit and drop to 0 on reset. An unchanged live choice keeps
// its value.
// Assumes: port_wr and commit are already gated by rst_n.
module xbs_sel_bank #(
    parameter int unsigned N_PORTS = 16,
    parameter int unsigned SEL_W   = 4,
    localparam int unsigned VEC_W  = N_PORTS * SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             port_wr,
    input  logic [SEL_W-1:0] wr_idx,
    input  logic [SEL_W-1:0] wr_val,
    input  logic             bulk_wr,
    input  logic [VEC_W-1:0] bulk_vec,
    input  logic             commit,
    output logic [VEC_W-1:0] live_vec
);
    logic [VEC_W-1:0] stage_vec;

    for (genvar k = 0; k < N_PORTS; k++) begin : g_port
        // Staged choice for output k; untouched while reset is low.
        always_ff @(posedge clk) begin
            if (rst_n) begin
                if (bulk_wr)
                    stage_vec[k*SEL_W +: SEL_W] <= bulk_vec[k*SEL_W +: SEL_W];
                else if (port_wr && (wr_idx == SEL_W'(k)))
                    stage_vec[k*SEL_W +: SEL_W] <= wr_val;
            end
        end

        // Live choice for output k: reset to input 0, else copy on commit.
        always_ff @(posedge clk) begin
            if (!rst_n)      live_vec[k*SEL_W +: SEL_W] <= '0;
            else if (commit) live_vec[k*SEL_W +: SEL_W] <= stage_vec[k*SEL_W +: SEL_W];
        end
    end

    // R4
    commit_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live_vec == $past(stage_vec)));
    // R5
    live_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(live_vec));
    // R6
    live_rst_chk: assert property (@(posedge clk) !rst_n |=> (live_vec == '0));
    // R7
    stage_keep_chk: assert property (@(posedge clk) !rst_n |=> $stable(stage_vec));
    // R2
    stage_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (port_wr && !bulk_wr) |=> (stage_vec[$past(wr_idx)*SEL_W +: SEL_W] == $past(wr_val)));
    // R10
    bulk_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bulk_wr |=> (stage_vec == $past(bulk_vec)));
endmodule

// File: rtl/xbs_mux_array.sv
// One independent N:1 multiplexer per output, steered by the live choices.
// Assumes: live choices are below N_PORTS (true for power-of-two counts).
module xbs_mux_array #(
    parameter int unsigned N_PORTS = 16,
    parameter int unsigned SEL_W   = 4,
    parameter int unsigned DATA_W  = 1
) (
    input  logic [N_PORTS*SEL_W-1:0]  live_vec,
    input  logic [N_PORTS*DATA_W-1:0] din,
    output logic [N_PORTS*DATA_W-1:0] dout
);
    for (genvar k = 0; k < N_PORTS; k++) begin : g_out
        logic [SEL_W-1:0] sel;
        assign sel = live_vec[k*SEL_W +: SEL_W];
        // Route the chosen input slice to output k.
        always_comb dout[k*DATA_W +: DATA_W] = din[sel*DATA_W +: DATA_W];
    end
endmodule

// File: rtl/xbar_two_stage.sv
// Non-blocking crosspoint with staged and live routing.
// Joins strobe control, the choice registers and the multiplexer array.
// Assumes: all control inputs are synchronous to clk; data paths are combinational.
module xbar_two_stage #(
    parameter int unsigned N_PORTS = xbs_pkg::XBS_PORTS_DEF,
    parameter int unsigned DATA_W  = xbs_pkg::XBS_DATA_DEF,
    localparam int unsigned SEL_W  = xbs_pkg::idx_width(N_PORTS),
    localparam int unsigned VEC_W  = N_PORTS * SEL_W,
    localparam int unsigned BUS_W  = N_PORTS * DATA_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [BUS_W-1:0] din,
    output logic [BUS_W-1:0] dout,
    input  logic             port_mode_n,
    input  logic             ld_stb,
    input  logic [SEL_W-1:0] src_idx,
    input  logic [SEL_W-1:0] dst_idx,
    input  logic             cfg_n,
    input  logic [VEC_W-1:0] seq_sel,
    input  logic             seq_load,
    input  logic             seq_commit,
    output logic             ready
);
    logic             port_wr;
    logic             commit;
    logic [VEC_W-1:0] live_vec;

    xbs_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .port_mode_n (port_mode_n),
        .ld_stb      (ld_stb),
        .cfg_n       (cfg_n),
        .seq_commit  (seq_commit),
        .port_wr     (port_wr),
        .commit      (commit),
        .ready       (ready)
    );

    xbs_sel_bank #(.N_PORTS(N_PORTS), .SEL_W(SEL_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .port_wr  (port_wr),
        .wr_idx   (dst_idx),
        .wr_val   (src_idx),
        .bulk_wr  (seq_load & rst_n),
        .bulk_vec (seq_sel),
        .commit   (commit),
        .live_vec (live_vec)
    );

    xbs_mux_array #(.N_PORTS(N_PORTS), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_mux (
        .live_vec (live_vec),
        .din      (din),
        .dout     (dout)
    );
endmodule

// File: tb/xbar_two_stage_bench.sv
`timescale 1ns/100ps
module xbar_two_stage_bench;
    localparam int N = 16;
    localparam int SW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  din = '0;
    logic [N-1:0]  dout;
    logic          port_mode_n = 1'b0;
    logic          ld_stb = 1'b0;
    logic [SW-1:0] src_idx = '0;
    logic [SW-1:0] dst_idx = '0;
    logic          cfg_n = 1'b1;
    logic [N*SW-1:0] seq_sel = '0;
    logic          seq_load = 1'b0;
    logic          seq_commit = 1'b0;
    logic          ready;

    int vectors = 0;
    int misses = 0;
    bit done = 0;
    logic [SW-1:0] m_stage [N];
    logic [SW-1:0] m_live [N];
    logic m_ready = 1'b0;

    always #2 clk = ~clk;

    xbar_two_stage u_xbar_two_stage (
        .clk(clk), .rst_n(rst_n), .din(din), .dout(dout),
        .port_mode_n(port_mode_n), .ld_stb(ld_stb), .src_idx(src_idx),
        .dst_idx(dst_idx), .cfg_n(cfg_n), .seq_sel(seq_sel),
        .seq_load(seq_load), .seq_commit(seq_commit), .ready(ready)
    );

    function automatic logic [N-1:0] exp_out(input logic [N-1:0] d);
        logic [N-1:0] r;
        for (int k = 0; k < N; k++) r[k] = d[m_live[k]];
        return r;
    endfunction

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_out(input string req);
        for (int i = 0; i < 2; i++) begin
            din = N'($urandom);
            #0.5;
            vectors++;
            if (dout !== exp_out(din)) begin
                misses++;
                $display("FAIL %s dout=%h expected=%h", req, dout, exp_out(din));
            end
        end
    endtask

    task automatic chk_rdy(input string req);
        vectors++;
        if (ready !== m_ready) begin
            misses++;
            $display("FAIL %s ready=%b expected=%b", req, ready, m_ready);
        end
    endtask

    task automatic port_load(input logic [SW-1:0] s, input logic [SW-1:0] d);
        ld_stb = 1'b1;
        step();
        m_ready = 1'b0;
        ld_stb = 1'b0; src_idx = s; dst_idx = d;
        step();
        if (!port_mode_n) begin
            m_stage[d] = s;
            m_ready = 1'b1;
        end
    endtask

    task automatic configure();
        cfg_n = 1'b0;
        step();
        for (int k = 0; k < N; k++) m_live[k] = m_stage[k];
        m_ready = 1'b0;
        cfg_n = 1'b1;
        step();
        m_ready = 1'b1;
    endtask

    task automatic wide_load();
        logic [N*SW-1:0] v;
        v = {$urandom, $urandom};
        seq_sel = v; seq_load = 1'b1;
        step();
        seq_load = 1'b0;
        for (int k = 0; k < N; k++) m_stage[k] = v[k*SW +: SW];
    endtask

    task automatic wide_commit();
        seq_commit = 1'b1;
        step();
        seq_commit = 1'b0;
        for (int k = 0; k < N; k++) m_live[k] = m_stage[k];
        m_ready = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        misses++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [SW-1:0] keep_src;
        logic hold_bit;
        void'($urandom(32'd8025));
        for (int k = 0; k < N; k++) begin m_stage[k] = '0; m_live[k] = '0; end
        @(negedge clk);
        repeat (4) step();
        chk_out("R6 reset routes input 0");
        chk_rdy("R6 ready low in reset");
        rst_n = 1'b1;
        step();

        // Program every output by port; nothing live yet.
        for (int k = 0; k < N; k++) port_load(SW'($urandom), SW'(k));
        chk_rdy("R9 ready after capture");
        chk_out("R2 capture not live before commit");
        configure();
        chk_out("R1 R4 routing after configure");
        chk_rdy("R9 ready after configure release");

        // Fan-out: several outputs on one input.
        for (int k = 0; k < 4; k++) port_load(4'd7, SW'(k));
        configure();
        chk_out("R1 fan-out of one input");

        // R8: a rising load clears ready.
        ld_stb = 1'b1;
        step();
        m_ready = 1'b0;
        chk_rdy("R8 load rise clears ready");
        ld_stb = 1'b0;
        step();
        m_stage[dst_idx] = src_idx; m_ready = 1'b1;

        // R8: ready low while configure held low.
        cfg_n = 1'b0;
        step();
        for (int k = 0; k < N; k++) m_live[k] = m_stage[k];
        m_ready = 1'b0;
        chk_rdy("R8 configure low clears ready");
        cfg_n = 1'b1;
        step();
        m_ready = 1'b1;

        // Random mix of operations.
        for (int it = 0; it < 60; it++) begin
            case ($urandom % 4)
                0, 1: port_load(SW'($urandom), SW'($urandom));
                2: configure();
                default: begin wide_load(); wide_commit(); end
            endcase
            chk_out("R1 R4 random sequence");
            chk_rdy("R9 random sequence ready");
        end

        // R3: port mode off ignores the address pair.
        port_mode_n = 1'b1;
        port_load(SW'(m_stage[5] + 1), 4'd5);
        port_mode_n = 1'b0;
        configure();
        chk_out("R3 mode high ignores capture");

        // R11: load held low captures once.
        port_load(4'd2, 4'd9);
        src_idx = 4'd11;
        repeat (3) step();
        configure();
        chk_out("R11 held-low load captures once");

        // R5: unchanged output passes data through a commit.
        keep_src = m_stage[3];
        port_load(SW'(m_stage[8] + 1), 4'd8);
        din = N'($urandom);
        #0.5;
        hold_bit = dout[3];
        cfg_n = 1'b0;
        @(posedge clk); #0.3;
        vectors++;
        if (dout[3] !== hold_bit || dout[3] !== din[keep_src]) begin
            misses++;
            $display("FAIL R5 unchanged output=%b expected=%b", dout[3], hold_bit);
        end
        @(negedge clk);
        for (int k = 0; k < N; k++) m_live[k] = m_stage[k];
        cfg_n = 1'b1;
        step();
        m_ready = 1'b1;
        chk_out("R5 routing after partial change");

        // R7: reset keeps staged routing; strobes during reset ignored.
        rst_n = 1'b0;
        step();
        for (int k = 0; k < N; k++) m_live[k] = '0;
        m_ready = 1'b0;
        chk_out("R6 outputs on input 0 after reset");
        chk_rdy("R6 ready cleared by reset");
        ld_stb = 1'b1; step();
        ld_stb = 1'b0; src_idx = 4'd1; dst_idx = 4'd0; step();
        seq_sel = '1; seq_load = 1'b1; step(); seq_load = 1'b0;
        rst_n = 1'b1;
        step();
        chk_out("R6 still input 0 before configure");
        configure();
        chk_out("R7 configure restores staged routing");

        // R10: wide write stages without going live.
        wide_load();
        chk_out("R10 wide write not live");
        wide_commit();
        chk_out("R10 wide commit routing");
        chk_rdy("R9 ready after wide commit");

        // R12: wide write and port capture on the same edge.
        ld_stb = 1'b1;
        step();
        m_ready = 1'b0;
        seq_sel = {$urandom, $urandom};
        ld_stb = 1'b0; src_idx = SW'(seq_sel[6*SW +: SW] + 1); dst_idx = 4'd6;
        seq_load = 1'b1;
        step();
        seq_load = 1'b0;
        for (int k = 0; k < N; k++) m_stage[k] = seq_sel[k*SW +: SW];
        m_ready = 1'b1;
        configure();
        chk_out("R12 wide write wins collision");

        finish_run();
    end
endmodule